// File: doc/BRIEF.md
# Dual-Loop Phase-Frequency Detector with Pump Control and Monitor Pin

This block holds two phase-frequency comparators, one per synthesizer loop. Each comparator watches a divided reference pulse train and a divided feedback pulse train, both synchronous to the system clock. It turns every pair of rising edges into source and sink commands for an external charge pump. A selectable polarity maps "reference ahead" to either a high or a low pump drive. The drive can be forced to high impedance, and it also falls to high impedance in power save. A fixed overlap of both commands is emitted even at zero phase error, so the loop has no dead zone.

Each loop also has a lock detector. One shared monitor pin reports, according to two 2-bit selects, one of these: a fixed low level, a lock flag, a raw pulse train, a fast-lock switch for a loop-filter resistor, or a counter-reset request. The pump is described as separate enable and level outputs, so the tri-state behaviour stays in synthesizable logic. Loop index 1 is the primary loop and loop index 0 is the secondary loop.

Top module: `pfd_pump_ctrl`

## Requirements
- R1: With `pol` high, a reference edge leading the feedback edge by d clock cycles gives exactly d cycles of `pump_oe`=1 with `pump_lvl`=1. A feedback edge leading by d gives d cycles with `pump_lvl`=0.
- R2: With `pol` low, the levels of R1 swap: a reference lead drives low and a feedback lead drives high, for the same number of cycles.
- R3: Equal arrival leaves `pump_oe` at 0. After every comparison, `pump_src` and `pump_snk` are both 1 together for exactly RST_DLY cycles (default 2). This overlap is the anti-dead-zone pulse.
- R4: While `force_z` of a loop is 1, that loop's `pump_oe`, `pump_src` and `pump_snk` stay 0 whatever the pulses do.
- R5: While `pwr_save` of a loop is 1, that loop's pump outputs stay 0 and its `lock` flag is cleared.
- R6: `pump_x4` repeats the `cur4x` bit of the same loop one clock later (0 = 1x current, 1 = 4x current).
- R7: `lock` rises after LOCK_CNT consecutive comparisons (default 8) in which the single-flag time stays at or below LOCK_WIN cycles (default 1). It does not rise after LOCK_CNT-1 such comparisons.
- R8: The first comparison whose single-flag time exceeds LOCK_WIN clears `lock`.
- R9: With `sel_fout`=00, `sel_lock` chooses the monitor level: 00 gives a driven 0, 01 gives `lock[0]`, 10 gives `lock[1]`, and 11 gives the AND of both flags. `mon_oe`=1 in all four cases.
- R10: `sel_fout`=10 shows loop 1 pulses and `sel_fout`=01 shows loop 0 pulses. `sel_lock[0]`=0 picks the reference pulse and 1 picks the feedback pulse. Each input pulse gives one high cycle on `mon_lvl`.
- R11: With `sel_fout`=11 and `sel_lock`=00 (fast lock), the pin is driven low (`mon_oe`=1, `mon_lvl`=0) while `cur4x[1]` is 1. It is released (`mon_oe`=0) while `cur4x[1]` is 0.
- R12: With `sel_fout`=11, `sel_lock` 01, 10 and 11 set `cnt_rst` to 01, 10 and 11 (bit 1 = loop 1, bit 0 = loop 0), and the pin is driven low. In every other mode `cnt_rst` is 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 2 | Divided reference pulse per loop |
| fb_in | input | 2 | Divided feedback pulse per loop |
| pol | input | 2 | Pump polarity per loop |
| cur4x | input | 2 | Pump current scale per loop |
| force_z | input | 2 | Forced high impedance per loop |
| pwr_save | input | 2 | Power save per loop |
| sel_lock | input | 2 | Monitor select, low pair |
| sel_fout | input | 2 | Monitor select, high pair |
| pump_oe | output | 2 | Pump drive enable (0 = high-Z) |
| pump_lvl | output | 2 | Pump drive level when enabled |
| pump_src | output | 2 | Source (drive-high) current command |
| pump_snk | output | 2 | Sink (drive-low) current command |
| pump_x4 | output | 2 | Current scale indication |
| lock | output | 2 | Lock flag per loop |
| mon_oe | output | 1 | Monitor pin drive enable |
| mon_lvl | output | 1 | Monitor pin level |
| cnt_rst | output | 2 | Divider reset request per loop |

## Verification
The bench sweeps reference leads and feedback leads of 1 to 4 cycles, plus equal arrival, under both polarities. It counts high-drive, low-drive and overlap cycles over each comparison. This separates polarity errors, off-by-one pulse widths and a missing anti-dead-zone overlap. Runs of in-window comparisons of length LOCK_CNT-1 and LOCK_CNT pin down the lock threshold, and a single wide comparison shows the clearing. Every monitor encoding is applied with one loop locked and the other unlocked, so the selection of the wrong loop or the wrong source shows up.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  localparam int LOOPS = 2;

  typedef enum logic [2:0] {
    MON_OFF,
    MON_LOCK,
    MON_PULSE,
    MON_FAST,
    MON_CRST
  } mon_kind_e;

  function automatic mon_kind_e mon_kind(input logic [1:0] fsel, input logic [1:0] lsel);
    mon_kind_e k;
    case (fsel)
      2'b00:   k = (lsel == 2'b00) ? MON_OFF : MON_LOCK;
      2'b11:   k = (lsel == 2'b00) ? MON_FAST : MON_CRST;
      default: k = MON_PULSE;
    endcase
    return k;
  endfunction
endpackage

// File: rtl/pfd_core.sv
module pfd_core #(
  parameter int RST_DLY = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic ref_in,
  input  logic fb_in,
  output logic up_o,
  output logic dn_o,
  output logic cmp_done_o,
  output logic ref_q_o,
  output logic fb_q_o
);
  localparam int OW = (RST_DLY < 2) ? 1 : $clog2(RST_DLY + 1);
  localparam logic [OW-1:0] OVL_LAST = OW'(RST_DLY - 1);

  logic          ref_q, fb_q, up, dn;
  logic [OW-1:0] ovl_cnt;
  logic          ref_edge, fb_edge, both, clear;

  assign ref_edge = ref_in & ~ref_q;
  assign fb_edge  = fb_in & ~fb_q;
  assign both     = up & dn;
  assign clear    = both && (ovl_cnt == OVL_LAST);

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      ref_q   <= 1'b0;
      fb_q    <= 1'b0;
      up      <= 1'b0;
      dn      <= 1'b0;
      ovl_cnt <= '0;
    end else begin
      ref_q   <= ref_in;
      fb_q    <= fb_in;
      up      <= (up & ~clear) | ref_edge;
      dn      <= (dn & ~clear) | fb_edge;
      ovl_cnt <= (!both || clear) ? '0 : ovl_cnt + 1'b1;
    end
  end

  assign up_o       = up;
  assign dn_o       = dn;
  assign cmp_done_o = clear;
  assign ref_q_o    = ref_q;
  assign fb_q_o     = fb_q;

  // R3: both flags release after the reset delay
  p_flags_drop_r3: assert property (@(posedge clk) disable iff (rst)
    (clear && !ref_edge && !fb_edge && !hold) |=> (!up_o && !dn_o));
endmodule

// File: rtl/lock_detect.sv
module lock_detect #(
  parameter int LOCK_WIN = 1,
  parameter int LOCK_CNT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic up,
  input  logic dn,
  input  logic cmp_done,
  output logic locked_o
);
  localparam int SW = $clog2(LOCK_WIN + 2);
  localparam int GW = $clog2(LOCK_CNT + 1);
  localparam logic [SW-1:0] SOLO_WIN = SW'(LOCK_WIN);
  localparam logic [SW-1:0] SOLO_SAT = SW'(LOCK_WIN + 1);
  localparam logic [GW-1:0] GOOD_TOP = GW'(LOCK_CNT);
  localparam logic [GW-1:0] GOOD_PRE = GW'(LOCK_CNT - 1);

  logic [SW-1:0] solo_cnt;
  logic [GW-1:0] good_cnt;
  logic          locked;

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      solo_cnt <= '0;
      good_cnt <= '0;
      locked   <= 1'b0;
    end else if (cmp_done) begin
      solo_cnt <= '0;
      if (solo_cnt <= SOLO_WIN) begin
        if (good_cnt < GOOD_TOP) good_cnt <= good_cnt + 1'b1;
        if (good_cnt >= GOOD_PRE) locked <= 1'b1;
      end else begin
        good_cnt <= '0;
        locked   <= 1'b0;
      end
    end else if ((up ^ dn) && (solo_cnt < SOLO_SAT)) begin
      solo_cnt <= solo_cnt + 1'b1;
    end
  end

  assign locked_o = locked;

  // R8: a wide comparison drops lock
  p_lock_drop_r8: assert property (@(posedge clk) disable iff (rst)
    (cmp_done && (solo_cnt > SOLO_WIN)) |=> !locked_o);
  // R7: lock only rises at the end of a comparison
  p_lock_rise_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(locked_o) |-> $past(cmp_done));
endmodule

// File: rtl/pump_drive.sv
module pump_drive (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic up,
  input  logic dn,
  input  logic pol,
  input  logic force_z,
  input  logic cur4x,
  output logic src_o,
  output logic snk_o,
  output logic oe_o,
  output logic lvl_o,
  output logic x4_o
);
  logic drv_on;
  assign drv_on = !force_z && !hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_o <= 1'b0;
      snk_o <= 1'b0;
      oe_o  <= 1'b0;
      lvl_o <= 1'b0;
      x4_o  <= 1'b0;
    end else begin
      src_o <= drv_on & (pol ? up : dn);
      snk_o <= drv_on & (pol ? dn : up);
      oe_o  <= drv_on & (up ^ dn);
      lvl_o <= drv_on & (pol ? (up & ~dn) : (dn & ~up));
      x4_o  <= cur4x;
    end
  end

  // R4 / R5: forced high impedance and power save silence the pump
  p_forced_z_r4: assert property (@(posedge clk) disable iff (rst)
    (force_z || hold) |=> (!oe_o && !src_o && !snk_o));
  // R6: current scale follows its bit
  p_x4_set_r6: assert property (@(posedge clk) disable iff (rst)
    cur4x |=> x4_o);
  p_x4_clr_r6: assert property (@(posedge clk) disable iff (rst)
    !cur4x |=> !x4_o);
  // R1: drive is only enabled with exactly one command active
  p_one_cmd_r1: assert property (@(posedge clk) disable iff (rst)
    oe_o |-> (src_o != snk_o));
endmodule

// File: rtl/mon_decode.sv
module mon_decode
  import pfd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       sel_lock,
  input  logic [1:0]       sel_fout,
  input  logic [LOOPS-1:0] locked,
  input  logic [LOOPS-1:0] ref_q,
  input  logic [LOOPS-1:0] fb_q,
  input  logic [LOOPS-1:0] cur4x,
  output logic             mon_oe,
  output logic             mon_lvl,
  output logic [LOOPS-1:0] cnt_rst
);
  mon_kind_e  kind;
  logic       nxt_oe, nxt_lvl, pick_hi;
  logic [LOOPS-1:0] nxt_rst;

  assign kind    = mon_kind(sel_fout, sel_lock);
  assign pick_hi = sel_fout[1];

  always_comb begin
    nxt_oe  = 1'b1;
    nxt_lvl = 1'b0;
    nxt_rst = '0;
    unique case (kind)
      MON_OFF:   nxt_lvl = 1'b0;
      MON_LOCK: begin
        case (sel_lock)
          2'b01:   nxt_lvl = locked[0];
          2'b10:   nxt_lvl = locked[1];
          default: nxt_lvl = locked[0] & locked[1];
        endcase
      end
      MON_PULSE: begin
        if (pick_hi) nxt_lvl = sel_lock[0] ? fb_q[1] : ref_q[1];
        else         nxt_lvl = sel_lock[0] ? fb_q[0] : ref_q[0];
      end
      MON_FAST:  nxt_oe  = cur4x[1];
      MON_CRST:  nxt_rst = sel_lock;
      default:   nxt_lvl = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mon_oe  <= 1'b1;
      mon_lvl <= 1'b0;
      cnt_rst <= '0;
    end else begin
      mon_oe  <= nxt_oe;
      mon_lvl <= nxt_lvl;
      cnt_rst <= nxt_rst;
    end
  end

  // R11: fast-lock pulls the pin low while 4x current is selected
  p_fast_low_r11: assert property (@(posedge clk) disable iff (rst)
    ((sel_fout == 2'b11) && (sel_lock == 2'b00) && cur4x[1]) |=> (mon_oe && !mon_lvl));
  // R12: reset requests exist only in the reset modes
  p_rst_mode_r12: assert property (@(posedge clk) disable iff (rst)
    (sel_fout != 2'b11) |=> (cnt_rst == '0));
endmodule

// File: rtl/pfd_pump_ctrl.sv
module pfd_pump_ctrl
  import pfd_pkg::*;
#(
  parameter int RST_DLY  = 2,
  parameter int LOCK_WIN = 1,
  parameter int LOCK_CNT = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] ref_in,
  input  logic [1:0] fb_in,
  input  logic [1:0] pol,
  input  logic [1:0] cur4x,
  input  logic [1:0] force_z,
  input  logic [1:0] pwr_save,
  input  logic [1:0] sel_lock,
  input  logic [1:0] sel_fout,
  output logic [1:0] pump_oe,
  output logic [1:0] pump_lvl,
  output logic [1:0] pump_src,
  output logic [1:0] pump_snk,
  output logic [1:0] pump_x4,
  output logic [1:0] lock,
  output logic       mon_oe,
  output logic       mon_lvl,
  output logic [1:0] cnt_rst
);
  logic [LOOPS-1:0] up, dn, cmp_done, ref_q, fb_q;

  for (genvar g = 0; g < LOOPS; g++) begin : g_loop
    pfd_core #(.RST_DLY(RST_DLY)) u_core (
      .clk(clk), .rst(rst), .hold(pwr_save[g]),
      .ref_in(ref_in[g]), .fb_in(fb_in[g]),
      .up_o(up[g]), .dn_o(dn[g]), .cmp_done_o(cmp_done[g]),
      .ref_q_o(ref_q[g]), .fb_q_o(fb_q[g])
    );

    lock_detect #(.LOCK_WIN(LOCK_WIN), .LOCK_CNT(LOCK_CNT)) u_lock (
      .clk(clk), .rst(rst), .hold(pwr_save[g]),
      .up(up[g]), .dn(dn[g]), .cmp_done(cmp_done[g]),
      .locked_o(lock[g])
    );

    pump_drive u_pump (
      .clk(clk), .rst(rst), .hold(pwr_save[g]),
      .up(up[g]), .dn(dn[g]), .pol(pol[g]), .force_z(force_z[g]),
      .cur4x(cur4x[g]),
      .src_o(pump_src[g]), .snk_o(pump_snk[g]), .oe_o(pump_oe[g]),
      .lvl_o(pump_lvl[g]), .x4_o(pump_x4[g])
    );
  end

  mon_decode u_mon (
    .clk(clk), .rst(rst), .sel_lock(sel_lock), .sel_fout(sel_fout),
    .locked(lock), .ref_q(ref_q), .fb_q(fb_q), .cur4x(cur4x),
    .mon_oe(mon_oe), .mon_lvl(mon_lvl), .cnt_rst(cnt_rst)
  );

  // R5: power save clears the lock flag
  p_save_unlock_r5: assert property (@(posedge clk) disable iff (rst)
    pwr_save[1] |=> !lock[1]);
endmodule

// File: tb/pfd_pump_ctrl_bench.sv
`timescale 1ns/1ps
module pfd_pump_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] ref_in = '0, fb_in = '0, pol = 2'b11, cur4x = '0;
  logic [1:0] force_z = '0, pwr_save = '0, sel_lock = '0, sel_fout = '0;
  logic [1:0] pump_oe, pump_lvl, pump_src, pump_snk, pump_x4, lock, cnt_rst;
  logic       mon_oe, mon_lvl;

  pfd_pump_ctrl u_pfd_pump_ctrl (
    .clk(clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in), .pol(pol),
    .cur4x(cur4x), .force_z(force_z), .pwr_save(pwr_save),
    .sel_lock(sel_lock), .sel_fout(sel_fout),
    .pump_oe(pump_oe), .pump_lvl(pump_lvl), .pump_src(pump_src),
    .pump_snk(pump_snk), .pump_x4(pump_x4), .lock(lock),
    .mon_oe(mon_oe), .mon_lvl(mon_lvl), .cnt_rst(cnt_rst)
  );

  always #2 clk = ~clk;

  localparam int OVL = 2;
  localparam int LCNT = 8;

  int n_chk = 0, n_fail = 0;
  bit counting = 0;
  int lp = 1;
  int c_hi, c_lo, c_src, c_snk, c_both, c_mon;

  always @(negedge clk) if (counting) begin
    if (pump_oe[lp] && pump_lvl[lp])  c_hi++;
    if (pump_oe[lp] && !pump_lvl[lp]) c_lo++;
    if (pump_src[lp]) c_src++;
    if (pump_snk[lp]) c_snk++;
    if (pump_src[lp] && pump_snk[lp]) c_both++;
    if (mon_oe && mon_lvl) c_mon++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // d > 0: reference leads by d cycles; d < 0: feedback leads by -d
  task automatic run_cmp(input int loop, input int d);
    int ad;
    ad = (d < 0) ? -d : d;
    lp = loop;
    c_hi = 0; c_lo = 0; c_src = 0; c_snk = 0; c_both = 0; c_mon = 0;
    counting = 1;
    for (int i = 0; i < ad + 10; i++) begin
      @(negedge clk);
      ref_in[loop] = (d >= 0) ? (i == 0) : (i == ad);
      fb_in[loop]  = (d >= 0) ? (i == ad) : (i == 0);
    end
    @(negedge clk);
    counting = 0;
    ref_in = '0;
    fb_in = '0;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wait_cyc(4);
    rst = 1'b0;
    wait_cyc(1);
    // reset state
    check(pump_oe == 2'b00, "R4 reset oe", pump_oe, 0);
    check(lock == 2'b00, "R7 reset lock", lock, 0);
    check(mon_oe && !mon_lvl, "R9 reset pin", mon_lvl, 0);
    check(cnt_rst == 2'b00, "R12 reset cnt_rst", cnt_rst, 0);

    // R1 polarity high, both directions, both loops
    for (int d = 1; d <= 4; d++) begin
      run_cmp(1, d);
      check(c_hi == d && c_lo == 0, "R1 ref lead high", c_hi, d);
      check(c_both == OVL, "R3 overlap after lead", c_both, OVL);
      run_cmp(1, -d);
      check(c_lo == d && c_hi == 0, "R1 fb lead low", c_lo, d);
    end
    run_cmp(0, 3);
    check(c_hi == 3 && c_lo == 0, "R1 loop0 ref lead", c_hi, 3);
    run_cmp(0, -2);
    check(c_lo == 2 && c_hi == 0, "R1 loop0 fb lead", c_lo, 2);

    // R2 polarity low
    pol = 2'b00;
    run_cmp(1, 3);
    check(c_lo == 3 && c_hi == 0, "R2 ref lead low", c_lo, 3);
    run_cmp(1, -2);
    check(c_hi == 2 && c_lo == 0, "R2 fb lead high", c_hi, 2);
    pol = 2'b11;

    // R3 equal arrival
    run_cmp(1, 0);
    check(c_hi + c_lo == 0, "R3 equal stays Z", c_hi + c_lo, 0);
    check(c_both == OVL && c_src == OVL && c_snk == OVL, "R3 anti-dead-zone", c_both, OVL);

    // R4 forced high impedance
    force_z = 2'b10;
    run_cmp(1, 3);
    check(c_hi + c_lo == 0, "R4 forced Z oe", c_hi + c_lo, 0);
    check(c_src + c_snk == 0, "R4 forced Z cmds", c_src + c_snk, 0);
    force_z = 2'b00;

    // R6 current scale
    cur4x = 2'b10;
    wait_cyc(2);
    check(pump_x4 == 2'b10, "R6 x4 set", pump_x4, 2);
    cur4x = 2'b00;
    wait_cyc(2);
    check(pump_x4 == 2'b00, "R6 x4 clear", pump_x4, 0);

    // R8 wide comparison -> unlocked; R7 threshold
    run_cmp(1, 4);
    run_cmp(0, 4);
    check(lock == 2'b00, "R8 unlocked after wide", lock, 0);
    for (int k = 0; k < LCNT - 1; k++) run_cmp(1, (k % 2 == 0) ? 1 : -1);
    check(lock[1] == 1'b0, "R7 not locked at N-1", lock[1], 0);
    run_cmp(1, 0);
    check(lock[1] == 1'b1, "R7 locked at N", lock[1], 1);

    // R9 lock-select encodings (loop1 locked, loop0 not)
    sel_fout = 2'b00; sel_lock = 2'b10; wait_cyc(2);
    check(mon_oe && mon_lvl, "R9 sel 10 loop1", mon_lvl, 1);
    sel_lock = 2'b01; wait_cyc(2);
    check(mon_oe && !mon_lvl, "R9 sel 01 loop0", mon_lvl, 0);
    sel_lock = 2'b11; wait_cyc(2);
    check(mon_oe && !mon_lvl, "R9 sel 11 and one", mon_lvl, 0);
    for (int k = 0; k < LCNT; k++) run_cmp(0, 0);
    check(lock == 2'b11, "R7 loop0 locked", lock, 3);
    check(mon_oe && mon_lvl, "R9 sel 11 and both", mon_lvl, 1);

    // R8 single wide comparison
    run_cmp(1, 3);
    check(lock == 2'b01, "R8 loop1 drops", lock, 1);

    // R5 power save
    pwr_save = 2'b01;
    wait_cyc(2);
    check(lock == 2'b00, "R5 save clears lock", lock, 0);
    run_cmp(0, 3);
    check(c_hi + c_lo + c_src + c_snk == 0, "R5 save silences pump", c_src + c_snk, 0);
    pwr_save = 2'b00;

    // R10 pulse monitor
    sel_fout = 2'b10; sel_lock = 2'b00;
    run_cmp(1, 2);
    check(c_mon == 1, "R10 loop1 ref pulse", c_mon, 1);
    sel_lock = 2'b01;
    run_cmp(1, 2);
    check(c_mon == 1, "R10 loop1 fb pulse", c_mon, 1);
    sel_fout = 2'b01;
    run_cmp(1, 2);
    check(c_mon == 0, "R10 loop0 ignores loop1", c_mon, 0);
    run_cmp(0, -2);
    check(c_mon == 1, "R10 loop0 fb pulse", c_mon, 1);

    // R11 fast lock
    sel_fout = 2'b11; sel_lock = 2'b00; cur4x = 2'b10; wait_cyc(2);
    check(mon_oe && !mon_lvl, "R11 fast low", mon_oe, 1);
    check(cnt_rst == 2'b00, "R12 fast no reset", cnt_rst, 0);
    cur4x = 2'b00; wait_cyc(2);
    check(!mon_oe, "R11 fast release", mon_oe, 0);

    // R12 counter reset modes
    for (int s = 1; s < 4; s++) begin
      sel_lock = 2'(s); wait_cyc(2);
      check(cnt_rst == 2'(s) && mon_oe && !mon_lvl, "R12 counter reset", cnt_rst, s);
    end
    sel_fout = 2'b00; sel_lock = 2'b00; wait_cyc(2);
    check(cnt_rst == 2'b00 && mon_oe && !mon_lvl, "R12 disabled mode", cnt_rst, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule